// File: doc/BRIEF.md
# Per-Scanline Sprite Evaluation Unit

This block decides which sprites show on the next scanline and then draws them. An external object table holds 64 sprites of 4 bytes each. The block reads that table through a byte-wide read port. When a line target and a height mode are given, it walks the sprites from index 0 upward. It copies every sprite that covers the line into an eight-entry secondary list. If a ninth covering sprite turns up, it raises an overflow flag. Unused list entries hold all-ones.

Once evaluation ends, an outside fetcher reads each list entry through a lookup port. That port gives the tile number and the row within the sprite, with vertical flip already applied. The fetcher returns the two pattern bytes of that row and loads them into one of eight per-slot shifters. Each shifter waits for its X count to run down, then sends out eight pixels, most significant bit first, or in reverse order when the sprite is mirrored horizontally. A priority stage picks the lowest-numbered opaque slot. It outputs that slot's two-bit pixel, its palette, its behind-background bit, and a flag that marks a pixel coming from sprite 0.

Byte layout per sprite at object address 4*i+k: k=0 vertical position, k=1 tile, k=2 attribute, k=3 horizontal position. Attribute bits: 7 vertical flip, 6 horizontal flip, 5 behind background, 1:0 palette.

Top module: `spr_line_eval`

## Requirements
- R1: Sprite i covers line L when the unsigned difference L - Y is between 0 and H-1, where H is 8 when `tall_mode`=0 and 16 when `tall_mode`=1. A sprite whose Y is greater than L never covers L.
- R2: After evaluation, list slots 0..k-1 hold the covering sprites in rising index order. `fetch_tile` for slot s returns the tile byte (offset 1) of the s-th covering sprite.
- R3: `overflow` is cleared when an evaluation starts. It is set when a ninth covering sprite is found, and evaluation stops at that sprite. Exactly eight covering sprites leave it clear.
- R4: A slot that receives no sprite reads back `fetch_tile` = 0xFF. That slot emits no pixel, whatever pattern bytes are loaded into it.
- R5: `zero_in_list` is 1 after evaluation exactly when sprite 0 was selected.
- R6: `fetch_row` is L - Y. When attribute bit 7 is set, it is H-1-(L-Y) instead.
- R7: Loading a slot sets its X counter. Each `pix_en` cycle decrements a non-zero counter. Pixels p = X..X+7 after a load show bit 7-(p-X) of `pat_hi` and `pat_lo` as {hi,lo}.
- R8: With attribute bit 6 set, the pattern bits come out in the reverse order, bit 0 first.
- R9: The output pixel comes from the lowest-numbered slot whose pixel is non-zero. `spr_pal` is that slot's attribute bits 1:0 and `spr_behind` is its bit 5. With no opaque slot, `spr_pix`=0.
- R10: `spr_zero_here` is 1 exactly when the output pixel comes from slot 0 and slot 0 was loaded while sprite 0 was in the list.
- R11: `busy` rises on the cycle after an accepted `eval_start`. It falls when the scan finishes, and it never rises without `eval_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_start | input | 1 | Start evaluation (accepted while idle) |
| target_line | input | 8 | Line being evaluated |
| tall_mode | input | 1 | 1 selects 16-row sprites, 0 selects 8-row |
| oam_addr | output | 8 | Object table byte address |
| oam_rdata | input | 8 | Object table byte at `oam_addr`, same cycle |
| busy | output | 1 | Evaluation in progress |
| overflow | output | 1 | More than eight covering sprites found |
| zero_in_list | output | 1 | Sprite 0 was selected |
| fetch_slot | input | 3 | List slot to look up |
| fetch_tile | output | 8 | Tile of the looked-up slot |
| fetch_row | output | 4 | Row within the sprite, flip applied |
| load_en | input | 1 | Load pattern bytes into a slot |
| load_slot | input | 3 | Slot to load |
| pat_lo | input | 8 | Pattern low plane byte |
| pat_hi | input | 8 | Pattern high plane byte |
| pix_en | input | 1 | Advance one pixel |
| spr_pix | output | 2 | Winning sprite pixel, 0 = transparent |
| spr_pal | output | 2 | Palette of winning sprite |
| spr_behind | output | 1 | Behind-background bit of winning sprite |
| spr_zero_here | output | 1 | Output pixel belongs to sprite 0 |

## Verification
The assertions assume that `target_line` and `tall_mode` stay fixed while `busy` is high. They also assume that `oam_rdata` is the table byte at `oam_addr` in the same cycle, and that no load is issued during a scan. The bench drives the line and height only while the block is idle. It models the table as a combinational array indexed by `oam_addr`, and it loads slots only after `busy` has fallen. It then checks each slot lookup and each rendered pixel against values worked out from the table contents.

// File: rtl/spr_pkg.sv
// Shared types for the sprite evaluation unit.
// Assumes byte-wide sprite fields; the row field covers heights up to 16.
package spr_pkg;
    localparam int BYTE_W = 8;
    localparam int ROW_W  = 4;

    // One secondary-list entry: the copied sprite bytes plus its row.
    typedef struct packed {
        logic [BYTE_W-1:0] ypos;
        logic [BYTE_W-1:0] tile;
        logic [BYTE_W-1:0] attr;
        logic [BYTE_W-1:0] xpos;
        logic [ROW_W-1:0]  row;
    } list_ent_t;
endpackage

// File: rtl/spr_eval_fsm.sv
// Walks the object table in index order and copies the covering sprites
// into the secondary list. Assumes a same-cycle read port, and a line and
// height that are held steady while busy. It stops at the first sprite
// past the list capacity and flags overflow.
module spr_eval_fsm
    import spr_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         eval_start,
    input  logic [7:0]                   target_line,
    input  logic                         tall_mode,
    output logic [$clog2(NUM_SPR)+1:0]   oam_addr,
    input  logic [7:0]                   oam_rdata,
    output logic                         busy,
    output logic                         overflow,
    output logic                         zero_sel,
    output logic [$clog2(SLOTS+1)-1:0]   sel_count,
    output list_ent_t                    list_o [SLOTS]
);
    localparam int IW = $clog2(NUM_SPR);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS+1);

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COPY} st_t;

    st_t             st_q;
    logic [IW-1:0]   idx_q;
    logic [1:0]      byte_q;
    logic [CW-1:0]   cnt_q;
    logic            ovf_q;
    logic            zsel_q;
    list_ent_t       list_q [SLOTS];

    logic [8:0]      diff9;
    logic [4:0]      height;
    logic [3:0]      row_max;
    logic            hit;
    logic            last;
    logic            full;
    logic [SW-1:0]   wr;

    // Coverage test for the sprite whose Y byte is on the read port.
    always_comb begin
        diff9   = {1'b0, target_line} - {1'b0, oam_rdata};
        height  = tall_mode ? 5'd16 : 5'd8;
        row_max = tall_mode ? 4'd15 : 4'd7;
        hit     = !diff9[8] && (diff9[7:0] < {3'b000, height});
        last    = (idx_q == IW'(NUM_SPR-1));
        full    = (cnt_q == CW'(SLOTS));
        wr      = cnt_q[SW-1:0];
    end

    // Scan, copy and overflow sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            byte_q <= 2'd0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            zsel_q <= 1'b0;
            for (int s = 0; s < SLOTS; s++) list_q[s] <= '1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (eval_start) begin
                        for (int s = 0; s < SLOTS; s++) list_q[s] <= '1;
                        cnt_q  <= '0;
                        ovf_q  <= 1'b0;
                        zsel_q <= 1'b0;
                        idx_q  <= '0;
                        byte_q <= 2'd0;
                        st_q   <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        if (full) begin
                            ovf_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            list_q[wr].ypos <= oam_rdata;
                            list_q[wr].row  <= diff9[3:0];
                            byte_q          <= 2'd1;
                            st_q            <= ST_COPY;
                            if (idx_q == '0) zsel_q <= 1'b1;
                        end
                    end else if (last) begin
                        st_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_COPY: begin
                    case (byte_q)
                        2'd1: list_q[wr].tile <= oam_rdata;
                        2'd2: begin
                            list_q[wr].attr <= oam_rdata;
                            if (oam_rdata[7]) list_q[wr].row <= row_max - list_q[wr].row;
                        end
                        default: list_q[wr].xpos <= oam_rdata;
                    endcase
                    if (byte_q == 2'd3) begin
                        cnt_q  <= cnt_q + 1'b1;
                        byte_q <= 2'd0;
                        if (last) begin
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_SCAN;
                        end
                    end else begin
                        byte_q <= byte_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign oam_addr  = {idx_q, byte_q};
    assign busy      = (st_q != ST_IDLE);
    assign overflow  = ovf_q;
    assign zero_sel  = zsel_q;
    assign sel_count = cnt_q;
    assign list_o    = list_q;
endmodule

// File: rtl/spr_slot.sv
// One sprite output lane: an X down-counter followed by two plane shifters.
// Assumes a load happens before the first pixel of the line. A load for an
// empty slot clears the planes so that the lane stays transparent.
module spr_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       valid,
    input  logic [7:0] attr,
    input  logic [7:0] xpos,
    input  logic [7:0] pat_lo,
    input  logic [7:0] pat_hi,
    input  logic       pix_en,
    output logic [1:0] pix_o,
    output logic [1:0] pal_o,
    output logic       behind_o
);
    logic [7:0] cnt_q;
    logic [7:0] lo_q;
    logic [7:0] hi_q;
    logic [1:0] pal_q;
    logic       beh_q;
    logic [7:0] lo_in;
    logic [7:0] hi_in;

    // Bit-order selection for horizontal mirroring, and empty-slot masking.
    always_comb begin
        for (int b = 0; b < 8; b++) begin
            lo_in[b] = valid & (attr[6] ? pat_lo[7-b] : pat_lo[b]);
            hi_in[b] = valid & (attr[6] ? pat_hi[7-b] : pat_hi[b]);
        end
    end

    // Counter run-down, then shift one pixel per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            pal_q <= '0;
            beh_q <= 1'b0;
        end else if (load) begin
            cnt_q <= xpos;
            lo_q  <= lo_in;
            hi_q  <= hi_in;
            pal_q <= attr[1:0];
            beh_q <= attr[5];
        end else if (pix_en) begin
            if (cnt_q != 8'd0) begin
                cnt_q <= cnt_q - 8'd1;
            end else begin
                lo_q <= {lo_q[6:0], 1'b0};
                hi_q <= {hi_q[6:0], 1'b0};
            end
        end
    end

    assign pix_o    = (cnt_q == 8'd0) ? {hi_q[7], lo_q[7]} : 2'b00;
    assign pal_o    = pal_q;
    assign behind_o = beh_q;
endmodule

// File: rtl/spr_pix_mux.sv
// Picks the lowest-numbered lane that shows an opaque pixel.
// Assumes that lane 0 has the highest priority.
module spr_pix_mux #(
    parameter int SLOTS = 8
) (
    input  logic [1:0] pix_i    [SLOTS],
    input  logic [1:0] pal_i    [SLOTS],
    input  logic       behind_i [SLOTS],
    output logic [1:0] pix_o,
    output logic [1:0] pal_o,
    output logic       behind_o,
    output logic       from_zero_o
);
    // Walk from the highest lane down so that lower lanes override.
    always_comb begin
        pix_o       = 2'b00;
        pal_o       = 2'b00;
        behind_o    = 1'b0;
        from_zero_o = 1'b0;
        for (int s = SLOTS-1; s >= 0; s--) begin
            if (pix_i[s] != 2'b00) begin
                pix_o       = pix_i[s];
                pal_o       = pal_i[s];
                behind_o    = behind_i[s];
                from_zero_o = (s == 0);
            end
        end
    end
endmodule

// File: rtl/spr_line_eval.sv
// Top of the sprite evaluation unit: the scan FSM, a lookup port for the
// pattern fetcher, eight generated output lanes and the priority stage.
// Assumes the fetcher loads the lanes only while no scan is running.
module spr_line_eval
    import spr_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eval_start,
    input  logic [7:0]                  target_line,
    input  logic                        tall_mode,
    output logic [$clog2(NUM_SPR)+1:0]  oam_addr,
    input  logic [7:0]                  oam_rdata,
    output logic                        busy,
    output logic                        overflow,
    output logic                        zero_in_list,
    input  logic [$clog2(SLOTS)-1:0]    fetch_slot,
    output logic [7:0]                  fetch_tile,
    output logic [3:0]                  fetch_row,
    input  logic                        load_en,
    input  logic [$clog2(SLOTS)-1:0]    load_slot,
    input  logic [7:0]                  pat_lo,
    input  logic [7:0]                  pat_hi,
    input  logic                        pix_en,
    output logic [1:0]                  spr_pix,
    output logic [1:0]                  spr_pal,
    output logic                        spr_behind,
    output logic                        spr_zero_here
);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS+1);

    list_ent_t      list_w [SLOTS];
    logic [CW-1:0]  sel_count;
    logic [1:0]     lane_pix [SLOTS];
    logic [1:0]     lane_pal [SLOTS];
    logic           lane_beh [SLOTS];
    logic           win_zero;
    logic           zero_loaded_q;

    spr_eval_fsm #(.NUM_SPR(NUM_SPR), .SLOTS(SLOTS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_start  (eval_start),
        .target_line (target_line),
        .tall_mode   (tall_mode),
        .oam_addr    (oam_addr),
        .oam_rdata   (oam_rdata),
        .busy        (busy),
        .overflow    (overflow),
        .zero_sel    (zero_in_list),
        .sel_count   (sel_count),
        .list_o      (list_w)
    );

    assign fetch_tile = list_w[fetch_slot].tile;
    assign fetch_row  = list_w[fetch_slot].row;

    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
        spr_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_en && (load_slot == SW'(s))),
            .valid    (CW'(s) < sel_count),
            .attr     (list_w[s].attr),
            .xpos     (list_w[s].xpos),
            .pat_lo   (pat_lo),
            .pat_hi   (pat_hi),
            .pix_en   (pix_en),
            .pix_o    (lane_pix[s]),
            .pal_o    (lane_pal[s]),
            .behind_o (lane_beh[s])
        );
    end

    spr_pix_mux #(.SLOTS(SLOTS)) u_mux (
        .pix_i       (lane_pix),
        .pal_i       (lane_pal),
        .behind_i    (lane_beh),
        .pix_o       (spr_pix),
        .pal_o       (spr_pal),
        .behind_o    (spr_behind),
        .from_zero_o (win_zero)
    );

    // Remember whether lane 0 holds sprite 0 at the moment it is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) zero_loaded_q <= 1'b0;
        else if (load_en && (load_slot == '0)) zero_loaded_q <= zero_in_list;
    end

    assign spr_zero_here = win_zero && zero_loaded_q;
endmodule

// File: rtl/spr_line_eval_chk.sv
// Temporal checks on the top-level ports of the sprite evaluation unit.
// Assumes the line and height inputs stay steady while busy.
module spr_line_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eval_start,
    input logic       busy,
    input logic       overflow,
    input logic       zero_in_list,
    input logic [7:0] oam_addr,
    input logic       load_en,
    input logic       pix_en,
    input logic [1:0] spr_pix,
    input logic [1:0] spr_pal,
    input logic       spr_zero_here
);
    // R11: a scan only begins on a start request.
    assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !eval_start) |=> !busy);

    // R3: a start clears the overflow flag.
    assert_ovf_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && eval_start) |=> !overflow);

    // R3: overflow can only appear as the result of a scan.
    assert_ovf_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(busy));

    // R5: the sprite-zero flag is set while reading sprite 0's Y byte.
    assert_zero_from_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_in_list) |-> ($past(oam_addr) == 8'd0));

    // R7: with no load and no advance the output pixel holds.
    assert_pix_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !load_en) |=> ($stable(spr_pix) && $stable(spr_pal)));

    // R10: a sprite-zero pixel is always opaque.
    assert_zero_opaque_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spr_zero_here |-> (spr_pix != 2'b00));
endmodule

bind spr_line_eval spr_line_eval_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eval_start    (eval_start),
    .busy          (busy),
    .overflow      (overflow),
    .zero_in_list  (zero_in_list),
    .oam_addr      (oam_addr),
    .load_en       (load_en),
    .pix_en        (pix_en),
    .spr_pix       (spr_pix),
    .spr_pal       (spr_pal),
    .spr_zero_here (spr_zero_here)
);

// File: tb/spr_line_eval_tb_top.sv
// Scoreboard bench: the driver pushes the expected pixels, and a monitor
// pops and compares them on each advanced pixel.
module spr_line_eval_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eval_start = 1'b0;
    logic [7:0] target_line = 8'd0;
    logic       tall_mode = 1'b0;
    logic [7:0] oam_addr;
    logic [7:0] oam_rdata;
    logic       busy, overflow, zero_in_list;
    logic [2:0] fetch_slot = 3'd0;
    logic [7:0] fetch_tile;
    logic [3:0] fetch_row;
    logic       load_en = 1'b0;
    logic [2:0] load_slot = 3'd0;
    logic [7:0] pat_lo = 8'd0, pat_hi = 8'd0;
    logic       pix_en = 1'b0;
    logic [1:0] spr_pix, spr_pal;
    logic       spr_behind, spr_zero_here;

    logic [7:0] mem [256];
    int         nchk = 0, nfail = 0;
    logic [5:0] exp_q [$];
    int         sel_idx [8];
    int         sel_n;
    bit         exp_ovf;
    int         cur_line, cur_h;

    always #2 clk = ~clk;
    assign oam_rdata = mem[oam_addr];

    spr_line_eval dut_i (.*);

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Monitor: compare each advanced pixel with the head of the queue.
    always @(negedge clk) begin
        if (pix_en && exp_q.size() > 0) begin
            logic [5:0] e;
            logic [5:0] a;
            e = exp_q.pop_front();
            a = {spr_zero_here, spr_behind, spr_pal, spr_pix};
            chk(a == e, "R4 R7 R8 R9 R10 pixel", int'(a), int'(e));
        end
    end

    function automatic logic [7:0] plo(input logic [7:0] t); return t ^ 8'h5A; endfunction
    function automatic logic [7:0] phi(input logic [7:0] t); return t + 8'h33; endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            mem[4*i]   = 8'hF0;
            mem[4*i+1] = 8'(i);
            mem[4*i+2] = 8'h00;
            mem[4*i+3] = 8'h00;
        end
    endtask

    task automatic put(input int i, input int y, input int t, input int a, input int x);
        mem[4*i] = 8'(y); mem[4*i+1] = 8'(t); mem[4*i+2] = 8'(a); mem[4*i+3] = 8'(x);
    endtask

    // Reference selection built from R1..R3.
    task automatic model_select();
        sel_n = 0; exp_ovf = 0;
        for (int i = 0; i < 64; i++) begin
            int d;
            d = cur_line - int'(mem[4*i]);
            if (d >= 0 && d < cur_h) begin
                if (sel_n == 8) begin exp_ovf = 1; break; end
                sel_idx[sel_n] = i; sel_n++;
            end
        end
    endtask

    task automatic run_eval(input int line, input bit tall);
        @(posedge clk); #1;
        target_line = 8'(line); tall_mode = tall; eval_start = 1'b1;
        cur_line = line; cur_h = tall ? 16 : 8;
        @(posedge clk); #1;
        eval_start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        while (busy) begin @(posedge clk); #1; end
        model_select();
        chk(overflow == exp_ovf, "R3 overflow", int'(overflow), int'(exp_ovf));
        chk(zero_in_list == (sel_n > 0 && sel_idx[0] == 0), "R5 zero_in_list",
            int'(zero_in_list), int'(sel_n > 0 && sel_idx[0] == 0));
        for (int s = 0; s < 8; s++) begin
            fetch_slot = 3'(s); #1;
            if (s < sel_n) begin
                int i, d, r;
                i = sel_idx[s];
                d = cur_line - int'(mem[4*i]);
                r = mem[4*i+2][7] ? (cur_h - 1 - d) : d;
                chk(fetch_tile == mem[4*i+1], "R1 R2 slot tile", int'(fetch_tile), int'(mem[4*i+1]));
                chk(fetch_row == 4'(r), "R6 slot row", int'(fetch_row), r);
            end else begin
                chk(fetch_tile == 8'hFF, "R4 empty slot tile", int'(fetch_tile), 255);
            end
        end
    endtask

    // Load every lane; empty lanes receive opaque-looking bytes on purpose.
    task automatic load_all();
        for (int s = 0; s < 8; s++) begin
            fetch_slot = 3'(s); #1;
            load_en = 1'b1; load_slot = 3'(s);
            pat_lo = (s < sel_n) ? plo(fetch_tile) : 8'hFF;
            pat_hi = (s < sel_n) ? phi(fetch_tile) : 8'hFF;
            @(posedge clk); #1;
        end
        load_en = 1'b0;
    endtask

    task automatic render(input int n);
        for (int p = 0; p < n; p++) begin
            logic [5:0] e;
            e = '0;
            for (int s = 0; s < sel_n; s++) begin
                int i, x, k, b;
                logic [7:0] a, t;
                logic [1:0] v;
                i = sel_idx[s]; x = mem[4*i+3]; a = mem[4*i+2]; t = mem[4*i+1];
                if (p >= x && p < x + 8) begin
                    k = p - x;
                    b = a[6] ? k : 7 - k;
                    v = {phi(t)[b], plo(t)[b]};
                    if (v != 2'b00) begin
                        e = {(s == 0 && i == 0), a[5], a[1:0], v};
                        break;
                    end
                end
            end
            exp_q.push_back(e);
        end
        pix_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 pix_en = 1'b0;
        @(posedge clk); #1;
        chk(exp_q.size() == 0, "R7 all pixels compared", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(4*150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(busy == 0, "R11 reset busy", int'(busy), 0);
        chk(overflow == 0, "R3 reset overflow", int'(overflow), 0);
        chk(zero_in_list == 0, "R5 reset zero flag", int'(zero_in_list), 0);
        chk(spr_pix == 0, "R9 reset pixel", int'(spr_pix), 0);

        // Short sprites, flips, overlap and sprite 0 in the list.
        put(0, 15, 8'h11, 8'h01, 4);
        put(1, 21, 8'h12, 8'h00, 0);
        put(2, 12, 8'h13, 8'h00, 0);
        put(3, 13, 8'h22, 8'hA2, 8);
        put(5, 20, 8'h33, 8'h43, 0);
        put(7, 255, 8'h44, 8'h00, 0);
        run_eval(20, 1'b0);
        load_all();
        render(24);

        // Tall sprites with more than eight covering: overflow.
        clear_mem();
        put(0, 4, 8'h01, 8'h00, 0);
        put(1, 5, 8'h40, 8'h80, 30);
        for (int i = 2; i <= 10; i++) put(i, 10, 8'h50 + i, i & 3, 40 + 2*i);
        run_eval(20, 1'b1);
        load_all();
        render(64);

        // Exactly eight at the top of the table: no overflow.
        clear_mem();
        for (int i = 56; i < 64; i++) put(i, 95, 8'h60 + i, (i & 1) ? 8'h60 : 8'h03, (i - 56) * 5);
        run_eval(100, 1'b0);
        load_all();
        render(48);

        // Nothing covers the line: every lane is empty.
        clear_mem();
        run_eval(200, 1'b0);
        load_all();
        render(16);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule